// File: doc/BRIEF.md
# Strobe-Latched Byte-Wide Memory Device Interface

This block is the device side of a byte-wide nonvolatile memory with an SRAM-style pin set. It has active-low chip enable, write enable and output enable, a 13-bit address and an 8-bit data bus. The bus is split into an input, an output and an output-enable so that the pad ring can build the bidirectional pin. Unlike a plain SRAM, every access must begin with a falling edge on chip enable. That edge captures the address, and the block then runs a fixed internal access. Once chip enable is high again and the access has finished, a mandatory precharge follows, and only after it can a new cycle begin.

All pins are asynchronous to the block's fast system clock. Each pin passes through a two-flop synchronizer, and edges are found on the synchronized chip enable and write enable. The access and precharge lengths are parameters counted in system-clock cycles.

A cycle is classed as a write when write enable is already low at the chip-enable fall. It is classed as a read that may later turn into a write when write enable falls afterwards. The storage is a register array of 1,024 rows of eight bytes, written one byte lane at a time. A chip-enable fall that arrives before the precharge has completed does not start a cycle. Instead it raises a sticky violation flag.

Top module: `strobe_mem_dev`

The data pins are a plain bus with no valid/ready handshake. Pacing comes entirely from the strobe protocol, so there is no back-pressure.

## Requirements
- R1: The address is captured when the synchronized chip enable falls. Address pin changes while chip enable stays low have no effect on which byte is read or written.
- R2: If write enable is low when chip enable falls, the cycle is a write and `dq_oe` stays 0 for the whole cycle, whatever `oe_n` does.
- R3: If write enable falls after chip enable has fallen, the cycle behaves as a read until then. It drives the stored byte while `oe_n` is low, releases the bus (`dq_oe`=0) within three clock cycles of the write-enable fall, and then writes.
- R4: A write stores the `dq_in` value that is present at the first rising edge of either write enable or chip enable. Exactly one byte is written per cycle, and later write-enable pulses in the same cycle are ignored.
- R5: `dq_oe`=1 only in a read cycle whose access has completed, with `oe_n` low and chip enable low. With `oe_n` already low, the drive starts on the (ACC_CYC+3)th rising clock edge after chip enable goes low at the pin. With `oe_n` high, `dq_oe` stays 0. Lowering `oe_n` later starts the drive.
- R6: Precharge lasts PRE_CYC cycles once chip enable is high and the access is done. A chip-enable fall before the precharge completes starts no cycle and sets `pc_violation`=1, which holds until reset. A new cycle needs a fresh fall after the precharge.
- R7: An access runs to completion even if chip enable rises early. A write ended by such an early rise is stored, and a read ended early never drives the bus.
- R8: The array holds 8,192 independent bytes. Address bits [12:3] pick one of 1,024 rows and bits [2:0] pick the byte inside the row. Writing one byte leaves the other bytes in its row, and all other rows, unchanged.
- R9: After reset `dq_oe`=0 and `pc_violation`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low; its fall starts a cycle |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 13 | Byte address, captured at the chip-enable fall |
| dq_in | input | 8 | Data from the bus pins |
| dq_out | output | 8 | Data to drive onto the bus |
| dq_oe | output | 1 | 1 while the bus pins must drive `dq_out` |
| pc_violation | output | 1 | Sticky flag: chip enable fell during precharge |

## Verification
The interesting coincidence is a write commit in the same cycle that chip enable rises. That rise both ends the write and starts the precharge, and when it comes mid-access it must also leave the access running. The bench provokes this in two ways. It releases chip enable with write enable still low after the access. It also pulls chip enable high two cycles into an access. In both cases it judges the result by reading the byte back in a later cycle and by checking that no precharge violation is reported.

// File: rtl/strobe_mem_pkg.sv
package strobe_mem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_ACCESS    = 2'd1,
    PH_READY     = 2'd2,
    PH_PRECHARGE = 2'd3
  } phase_e;

endpackage

// File: rtl/strobe_mem_sync.sv
module strobe_mem_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/strobe_mem_ctrl.sv
module strobe_mem_ctrl
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 7,
  parameter int PRE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output phase_e            phase,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              cyc_start,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              bus_en,
  output logic              violation
);

  localparam int CNT_MAX = (ACC_CYC > PRE_CYC) ? ACC_CYC : PRE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_CYC - 1);

  logic             ce_d, we_d;
  logic             ce_fall, ce_rise, we_fall, we_rise;
  logic [CNT_W-1:0] cnt;
  logic             cyc_wr;   // cycle is (or became) a write
  logic             wr_done;  // the one write of this cycle happened
  logic             ce_rel;   // chip enable rose during the access
  logic             in_cycle, live;

  assign ce_fall  = ce_d & ~ce_s;
  assign ce_rise  = ~ce_d & ce_s;
  assign we_fall  = we_d & ~we_s;
  assign we_rise  = ~we_d & we_s;

  assign in_cycle = (phase == PH_ACCESS) || (phase == PH_READY);
  assign live     = in_cycle && !ce_rel;

  assign cyc_start = (phase == PH_IDLE) && ce_fall;
  assign mem_we    = live && cyc_wr && !wr_done && (we_rise || ce_rise);
  assign mem_wdata = din_s;
  assign bus_en    = (phase == PH_READY) && !cyc_wr && !oe_s && !ce_s && we_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      lat_addr  <= '0;
      cyc_wr    <= 1'b0;
      wr_done   <= 1'b0;
      ce_rel    <= 1'b0;
      violation <= 1'b0;
      ce_d      <= 1'b1;
      we_d      <= 1'b1;
    end else begin
      ce_d <= ce_s;
      we_d <= we_s;
      if (mem_we)            wr_done <= 1'b1;
      if (live && we_fall)   cyc_wr  <= 1'b1;
      case (phase)
        PH_IDLE: begin
          if (ce_fall) begin
            phase    <= PH_ACCESS;
            cnt      <= ACC_LOAD;
            lat_addr <= addr_s;
            cyc_wr   <= ~we_s;
            wr_done  <= 1'b0;
            ce_rel   <= 1'b0;
          end
        end
        PH_ACCESS: begin
          if (ce_rise)           ce_rel    <= 1'b1;
          if (ce_fall && ce_rel) violation <= 1'b1;
          if (cnt == '0) begin
            if (ce_rel || ce_rise) begin
              phase <= PH_PRECHARGE;
              cnt   <= PRE_LOAD;
            end else begin
              phase <= PH_READY;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_READY: begin
          if (ce_rise) begin
            phase <= PH_PRECHARGE;
            cnt   <= PRE_LOAD;
          end
        end
        PH_PRECHARGE: begin
          if (ce_fall) violation <= 1'b1;
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strobe_mem_rows.sv
module strobe_mem_rows #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LANE_W   = $clog2(ROW_BYTES);
  localparam int ROW_W    = ADDR_W - LANE_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int ROW_BITS = DATA_W * ROW_BYTES;

  logic [ROW_BITS-1:0] rows_q [ROWS];
  logic [ROW_W-1:0]    row_sel;
  logic [LANE_W-1:0]   lane_sel;
  logic [ROW_BITS-1:0] row_bits;
  logic [DATA_W-1:0]   lanes [ROW_BYTES];

  assign row_sel  = addr[ADDR_W-1:LANE_W];
  assign lane_sel = addr[LANE_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) rows_q[row_sel][lane_sel*DATA_W +: DATA_W] <= wr_data;
  end

  assign row_bits = rows_q[row_sel];

  generate
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
      assign lanes[g] = row_bits[g*DATA_W +: DATA_W];
    end
  endgenerate

  assign rd_data = lanes[lane_sel];

endmodule

// File: rtl/strobe_mem_dev.sv
module strobe_mem_dev
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 8,
  parameter int SYNC_STG  = 2,
  parameter int ACC_CYC   = 7,
  parameter int PRE_CYC   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              pc_violation
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic [2:0]        ctl_s;
  logic [BUS_W-1:0]  bus_s;
  phase_e            phase;
  logic [ADDR_W-1:0] lat_addr;
  logic              cyc_start;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;

  strobe_mem_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(ctl_s)
  );

  strobe_mem_sync #(.W(BUS_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(bus_s)
  );

  strobe_mem_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .PRE_CYC(PRE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ctl_s[2]), .we_s(ctl_s[1]), .oe_s(ctl_s[0]),
    .addr_s(bus_s[BUS_W-1:DATA_W]), .din_s(bus_s[DATA_W-1:0]),
    .phase(phase), .lat_addr(lat_addr), .cyc_start(cyc_start),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .bus_en(dq_oe),
    .violation(pc_violation)
  );

  strobe_mem_rows #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES)) u_rows (
    .clk(clk), .wr_en(mem_we), .addr(lat_addr), .wr_data(mem_wdata), .rd_data(dq_out)
  );

endmodule

// File: rtl/strobe_mem_chk.sv
module strobe_mem_chk
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int ACC_CYC = 7,
  parameter int PRE_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic              cyc_start,
  input logic              mem_we,
  input logic [ADDR_W-1:0] lat_addr,
  input logic              dq_oe,
  input logic              pc_violation
);

  logic [15:0] since_start;
  logic [15:0] pre_len;
  logic        wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_start <= '0;
      pre_len     <= '0;
      wrote       <= 1'b0;
    end else begin
      if (cyc_start)                 since_start <= '0;
      else if (since_start != 16'hFFFF) since_start <= since_start + 1'b1;
      if (phase == PH_PRECHARGE)     pre_len <= pre_len + 1'b1;
      else                           pre_len <= '0;
      if (cyc_start)                 wrote <= 1'b0;
      else if (mem_we)               wrote <= 1'b1;
    end
  end

  assert_drive_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (since_start >= 16'(ACC_CYC)));

  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wrote);

  assert_write_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_ACCESS || phase == PH_READY));

  assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(lat_addr));

  assert_violation_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_violation |=> pc_violation);

  assert_precharge_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase) == PH_PRECHARGE) |-> (pre_len == 16'(PRE_CYC)));

  assert_no_start_in_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRECHARGE) |=> (phase == PH_PRECHARGE || phase == PH_IDLE));

endmodule

bind strobe_mem_dev strobe_mem_chk #(
  .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .PRE_CYC(PRE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .cyc_start(cyc_start),
  .mem_we(mem_we), .lat_addr(lat_addr), .dq_oe(dq_oe), .pc_violation(pc_violation)
);

// File: tb/strobe_mem_dev_test.sv
module strobe_mem_dev_test;

  localparam int ACC = 7;
  localparam int PRE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic        pc_violation;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] model [int];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  strobe_mem_dev #(.ACC_CYC(ACC), .PRE_CYC(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .pc_violation(pc_violation)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // Monitor: every new bus drive must match the next expected byte.
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (dq_oe && !prev_oe) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 drive with nothing expected", dq_out, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dq_out == e, t, dq_out, e);
      end
    end
    prev_oe = dq_oe;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [12:0] a, input string tag, input bit move_addr);
    exp_q.push_back(model[int'(a)]);
    tag_q.push_back(tag);
    @(negedge clk);
    addr = a; oe_n = 1'b0; ce_n = 1'b0;
    if (move_addr) begin
      @(negedge clk);
      addr = ~a;
    end
    wait_n(ACC + 6);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(PRE + 5);
  endtask

  task automatic wr_ce(input logic [12:0] a, input logic [7:0] d);
    bit quiet = 1;
    @(negedge clk);
    addr = a; dq_in = d; we_n = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    addr = ~a;
    repeat (ACC + 6) begin
      @(negedge clk);
      if (dq_oe) quiet = 0;
    end
    check(quiet, "R2 no drive in write cycle", 0, 0);
    ce_n = 1'b1;
    wait_n(3);
    we_n = 1'b1; oe_n = 1'b1; dq_in = 8'h00;
    wait_n(PRE + 4);
    model[int'(a)] = d;
  endtask

  task automatic wr_we(input logic [12:0] a, input logic [7:0] d_early, input logic [7:0] d_final);
    exp_q.push_back(model[int'(a)]);
    tag_q.push_back("R3 read phase before write");
    @(negedge clk);
    addr = a; oe_n = 1'b0; ce_n = 1'b0;
    wait_n(ACC + 6);
    check(exp_q.size() == 0, "R3 drove before write", exp_q.size(), 0);
    we_n = 1'b0; dq_in = d_early;
    wait_n(3);
    check(dq_oe == 1'b0, "R3 bus released after write enable", dq_oe, 0);
    dq_in = d_final;
    wait_n(2);
    we_n = 1'b1;
    wait_n(3);
    dq_in = 8'h5A; we_n = 1'b0;
    wait_n(3);
    we_n = 1'b1;
    wait_n(3);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(PRE + 4);
    model[int'(a)] = d_final;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit quiet;
    wait_n(5);
    check(dq_oe == 1'b0, "R9 reset bus off", dq_oe, 0);
    check(pc_violation == 1'b0, "R9 reset flag clear", pc_violation, 0);
    rst_n = 1'b1;
    wait_n(3);

    // R2 write with write enable low at the strobe; R1 address moved mid-cycle
    wr_ce(13'h0100, 8'hA1);
    wr_ce(13'h0ABC, 8'h3C);
    rd(13'h0100, "R1 latched address read", 1'b1);
    rd(13'h0ABC, "R2 write readback", 1'b0);

    // R5 exact drive latency with oe_n already low
    exp_q.push_back(model[32'h0100]); tag_q.push_back("R5 latency data");
    @(negedge clk);
    addr = 13'h0100; oe_n = 1'b0; ce_n = 1'b0;
    repeat (ACC + 2) @(posedge clk);
    @(negedge clk);
    check(dq_oe == 1'b0, "R5 no drive before access end", dq_oe, 0);
    @(posedge clk);
    @(negedge clk);
    check(dq_oe == 1'b1, "R5 drive at access end", dq_oe, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(PRE + 5);

    // R5 oe_n high keeps the bus off, late oe_n low starts the drive
    @(negedge clk);
    addr = 13'h0ABC; ce_n = 1'b0;
    quiet = 1;
    repeat (ACC + 8) begin
      @(negedge clk);
      if (dq_oe) quiet = 0;
    end
    check(quiet, "R5 oe high keeps bus off", 0, 0);
    exp_q.push_back(model[32'h0ABC]); tag_q.push_back("R5 late output enable data");
    oe_n = 1'b0;
    wait_n(4);
    check(dq_oe == 1'b1, "R5 late output enable drives", dq_oe, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(PRE + 5);

    // R3/R4 write enable falling inside a read cycle, second pulse ignored
    wr_ce(13'h0200, 8'h77);
    wr_we(13'h0200, 8'h11, 8'h22);
    rd(13'h0200, "R4 data at write enable rise", 1'b0);

    // R8 bytes of one row, next row, highest and lowest address
    for (int i = 0; i < 8; i++) wr_ce(13'h1238 + 13'(i), 8'h40 + 8'(i * 3));
    wr_ce(13'h1240, 8'hC5);
    wr_ce(13'h1FFF, 8'h99);
    wr_ce(13'h0000, 8'h5E);
    for (int i = 0; i < 8; i++) rd(13'h1238 + 13'(i), "R8 byte inside row", 1'b0);
    rd(13'h1240, "R8 next row", 1'b0);
    rd(13'h1FFF, "R8 top address", 1'b0);
    rd(13'h0000, "R8 bottom address", 1'b0);

    // R7 short strobe write, short strobe read
    @(negedge clk);
    addr = 13'h0333; dq_in = 8'hB7; we_n = 1'b0; ce_n = 1'b0;
    wait_n(2);
    ce_n = 1'b1;
    wait_n(2);
    we_n = 1'b1;
    wait_n(ACC + PRE + 8);
    model[32'h0333] = 8'hB7;
    @(negedge clk);
    addr = 13'h0333; oe_n = 1'b0; ce_n = 1'b0;
    wait_n(2);
    ce_n = 1'b1;
    quiet = 1;
    repeat (ACC + PRE + 8) begin
      @(negedge clk);
      if (dq_oe) quiet = 0;
    end
    oe_n = 1'b1;
    check(quiet, "R7 short read never drives", 0, 0);
    rd(13'h0333, "R7 short strobe write stored", 1'b0);
    check(pc_violation == 1'b0, "R6 clean precharges leave flag clear", pc_violation, 0);

    // R6 strobe inside precharge
    exp_q.push_back(model[32'h0100]); tag_q.push_back("R6 read before violation");
    @(negedge clk);
    addr = 13'h0100; oe_n = 1'b0; ce_n = 1'b0;
    wait_n(ACC + 6);
    ce_n = 1'b1;
    wait_n(2);
    ce_n = 1'b0;
    wait_n(4);
    check(pc_violation == 1'b1, "R6 early strobe flagged", pc_violation, 1);
    quiet = 1;
    repeat (20) begin
      @(negedge clk);
      if (dq_oe) quiet = 0;
    end
    check(quiet, "R6 early strobe starts no cycle", 0, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_n(PRE + 5);
    rd(13'h1FFF, "R6 fresh strobe after precharge", 1'b0);
    check(pc_violation == 1'b1, "R6 flag is sticky", pc_violation, 1);

    check(exp_q.size() == 0, "R5 all expected drives seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule